// File: doc/BRIEF.md
# Iterative Radix-16 Significand Multiplier

This block forms the exact product of two binary64 significands over several clock cycles and hands the result to a rounding stage. A caller presents both operands as raw biased exponent and fraction fields with a one-cycle `start` pulse. The block restores the implicit leading one. It pre-normalizes a subnormal operand and adjusts the working exponent to match. It then retires four multiplier bits per cycle with a shift-and-add accumulator. The result is a normalized 53-bit significand, a guard bit, a sticky bit and a signed exponent that may fall outside the representable range. Rounding, special values and exception flags belong to the stage downstream.

A state machine sequences the work. IDLE waits for `start`. From IDLE the machine takes one of three transitions. A zero operand goes straight to DONE. Two normal operands go to MULT. Any subnormal operand goes to NORM. NORM shifts each subnormal significand left by one place per cycle until its leading bit is set, then moves on to MULT. MULT runs fourteen radix-16 steps and then moves to FIX. FIX makes the single normalizing adjustment, registers the results and moves to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `fmul_sig_iter`

## Requirements
- R1: After reset `busy` and `done` are 0, and `prod_sig`, `prod_guard`, `prod_sticky` and `prod_exp` are all 0.
- R2: For two normal operands (exponent field not 0), `prod_sig` is the top 53 bits of the exact 106-bit product of the two significands `{1,fraction}`. `prod_exp` is `a_exp + b_exp - 1023`, plus 1 when the product is 2.0 or larger.
- R3: `prod_guard` is the product bit just below `prod_sig`. `prod_sticky` is the OR of every product bit below the guard bit.
- R4: An operand with exponent field 0 and a nonzero fraction is a subnormal. Its significand is `{0,fraction}` with an effective exponent of 1. It is shifted left until bit 52 is 1, and the exponent drops by one for each shift.
- R5: An operand with exponent field 0 and fraction 0 gives a zero result. `prod_sig`, `prod_guard`, `prod_sticky` and `prod_exp` are all 0, and `done` is raised on the edge after `start`.
- R6: `busy` is 1 from the edge that accepts `start` through the cycle in which `done` is 1. `done` is a single-cycle pulse.
- R7: A `start` that arrives while `busy` is 1 is ignored. The operation in progress completes with its own result, and no extra `done` follows.
- R8: With two normal operands, `done` is 1 after the 15th rising edge following the edge that samples `start`.
- R9: `prod_exp` is a 13-bit two's complement value. It carries exponents below 1 and above 2046 without wrapping, over the full range reachable from any pair of inputs.
- R10: While `busy` is 0, all result outputs keep the values from the last operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled when idle |
| a_exp | input | 11 | Biased exponent field of operand A |
| a_frac | input | 52 | Fraction field of operand A |
| b_exp | input | 11 | Biased exponent field of operand B |
| b_frac | input | 52 | Fraction field of operand B |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| prod_sig | output | 53 | Normalized product significand, leading one at bit 52 |
| prod_guard | output | 1 | First product bit below `prod_sig` |
| prod_sticky | output | 1 | OR of all product bits below the guard bit |
| prod_exp | output | 13 | Signed unbiased-adjusted product exponent |

## Verification
Unit operands check the exponent arithmetic with a product of exactly 1.0. Operands of 1.5 and of all-ones fractions cross 2.0 and so exercise the exponent increment. Single low-order fraction bits separate a set sticky bit from a clear guard bit. Subnormal-by-normal, subnormal-by-subnormal, largest-exponent and zero operands probe the pre-normalization count, the negative and large signed exponents, and the short zero path. A scoreboard of pseudo-random normal and subnormal operands is compared against an exact 106-bit product computed in the bench. A second `start` issued mid-operation shows whether the block stays on the request it accepted first.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_MULT,
        ST_FIX,
        ST_DONE
    } fmul_state_t;

endpackage

// File: rtl/fmul_unpack.sv
// Restores the implicit bit of one operand, or prepares a subnormal
// significand (already doubled) for the iterative normalization.
module fmul_unpack #(
    parameter int unsigned FRAC_W = 52,
    parameter int unsigned EIN_W  = 11
) (
    input  logic [EIN_W-1:0]  exp_field,
    input  logic [FRAC_W-1:0] frac_field,
    output logic [FRAC_W:0]   sig,
    output logic              is_zero
);
    logic exp_nz;

    assign exp_nz  = |exp_field;
    assign is_zero = !exp_nz && (frac_field == '0);
    assign sig     = exp_nz ? {1'b1, frac_field} : {frac_field, 1'b0};
endmodule

// File: rtl/fmul_radix_step.sv
// One radix-2^RADIX shift-and-add step of the significand product.
module fmul_radix_step #(
    parameter int unsigned ACC_W = 64,
    parameter int unsigned RADIX = 4
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] mcand,
    input  logic [RADIX-1:0] digit,
    output logic [ACC_W-1:0] acc_next,
    output logic [RADIX-1:0] dropped
);
    logic [ACC_W-1:0] term [RADIX];

    for (genvar i = 0; i < RADIX; i++) begin : g_term
        assign term[i] = digit[i] ? (mcand << i) : '0;
    end

    assign dropped = acc[RADIX-1:0];

    always_comb begin
        acc_next = acc >> RADIX;
        for (int i = 0; i < RADIX; i++) begin
            acc_next = acc_next + term[i];
        end
    end
endmodule

// File: rtl/fmul_sig_iter.sv
module fmul_sig_iter #(
    parameter int unsigned FRAC_W = 52,
    parameter int unsigned EIN_W  = 11,
    parameter int unsigned EXP_W  = 13,
    parameter int unsigned BIAS   = 1023
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EIN_W-1:0]        a_exp,
    input  logic [FRAC_W-1:0]       a_frac,
    input  logic [EIN_W-1:0]        b_exp,
    input  logic [FRAC_W-1:0]       b_frac,
    output logic                    busy,
    output logic                    done,
    output logic [FRAC_W:0]         prod_sig,
    output logic                    prod_guard,
    output logic                    prod_sticky,
    output logic signed [EXP_W-1:0] prod_exp
);
    import fmul_pkg::*;

    localparam int unsigned SIG_W   = FRAC_W + 1;
    localparam int unsigned RADIX   = 4;
    localparam int unsigned PRE     = 7;
    localparam int unsigned ITER    = (SIG_W + RADIX - 1) / RADIX;
    localparam int unsigned SHIFTED = RADIX * (ITER - 1);
    localparam int unsigned TOP     = 2 * SIG_W - 1 + PRE - SHIFTED;
    localparam int unsigned ACC_W   = TOP + RADIX;
    localparam int unsigned GRD     = TOP - SIG_W;
    localparam int unsigned CNT_W   = $clog2(ITER);

    fmul_state_t state_q, state_d;

    logic [SIG_W-1:0]        sa_q, sb_q, sa_in, sb_in;
    logic                    za, zb;
    logic signed [EXP_W-1:0] exp_q;
    logic [ACC_W-1:0]        acc_q, acc_step, mcand, fixed;
    logic [RADIX-1:0]        dropped;
    logic                    sticky_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    a_ready, b_ready;

    fmul_unpack #(.FRAC_W(FRAC_W), .EIN_W(EIN_W)) u_unpack_a (
        .exp_field(a_exp), .frac_field(a_frac), .sig(sa_in), .is_zero(za));
    fmul_unpack #(.FRAC_W(FRAC_W), .EIN_W(EIN_W)) u_unpack_b (
        .exp_field(b_exp), .frac_field(b_frac), .sig(sb_in), .is_zero(zb));

    assign mcand = ACC_W'(sb_q) << PRE;

    fmul_radix_step #(.ACC_W(ACC_W), .RADIX(RADIX)) u_step (
        .acc(acc_q), .mcand(mcand), .digit(sa_q[RADIX-1:0]),
        .acc_next(acc_step), .dropped(dropped));

    assign a_ready = sa_q[SIG_W-1];
    assign b_ready = sb_q[SIG_W-1];
    assign fixed   = acc_q[TOP] ? acc_q : (acc_q << 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                if (za || zb)                          state_d = ST_DONE;
                else if (sa_in[SIG_W-1] && sb_in[SIG_W-1]) state_d = ST_MULT;
                else                                   state_d = ST_NORM;
            end
            ST_NORM: if (a_ready && b_ready) state_d = ST_MULT;
            ST_MULT: if (cnt_q == CNT_W'(ITER - 1)) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa_q        <= '0;
            sb_q        <= '0;
            exp_q       <= '0;
            acc_q       <= '0;
            sticky_q    <= 1'b0;
            cnt_q       <= '0;
            prod_sig    <= '0;
            prod_guard  <= 1'b0;
            prod_sticky <= 1'b0;
            prod_exp    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    sa_q     <= sa_in;
                    sb_q     <= sb_in;
                    exp_q    <= EXP_W'(a_exp) + EXP_W'(b_exp) - EXP_W'(BIAS);
                    acc_q    <= '0;
                    sticky_q <= 1'b0;
                    cnt_q    <= '0;
                    if (za || zb) begin
                        prod_sig    <= '0;
                        prod_guard  <= 1'b0;
                        prod_sticky <= 1'b0;
                        prod_exp    <= '0;
                    end
                end
                ST_NORM: begin
                    if (!a_ready) sa_q <= sa_q << 1;
                    if (!b_ready) sb_q <= sb_q << 1;
                    exp_q <= exp_q - EXP_W'(!a_ready) - EXP_W'(!b_ready);
                end
                ST_MULT: begin
                    acc_q    <= acc_step;
                    sticky_q <= sticky_q | (|dropped);
                    sa_q     <= sa_q >> RADIX;
                    cnt_q    <= cnt_q + 1'b1;
                end
                ST_FIX: begin
                    prod_sig    <= fixed[TOP -: SIG_W];
                    prod_guard  <= fixed[GRD];
                    prod_sticky <= sticky_q | (|fixed[GRD-1:0]);
                    prod_exp    <= acc_q[TOP] ? exp_q + 1'b1 : exp_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Assertions
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_normalized_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod_sig[SIG_W-1] || prod_sig == '0));
    assert_zero_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prod_sig == '0) |-> (!prod_guard && !prod_sticky && prod_exp == '0));
    assert_iter_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MULT) |-> (cnt_q < CNT_W'(ITER)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ($stable(prod_sig) && $stable(prod_exp) && $stable(prod_guard)
                   && $stable(prod_sticky)));
endmodule

// File: tb/tb_fmul_sig_iter.sv
module tb_fmul_sig_iter;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [10:0]        a_exp = '0, b_exp = '0;
    logic [51:0]        a_frac = '0, b_frac = '0;
    logic               busy, done;
    logic [52:0]        prod_sig;
    logic               prod_guard, prod_sticky;
    logic signed [12:0] prod_exp;

    fmul_sig_iter dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_exp(a_exp), .a_frac(a_frac), .b_exp(b_exp), .b_frac(b_frac),
        .busy(busy), .done(done), .prod_sig(prod_sig), .prod_guard(prod_guard),
        .prod_sticky(prod_sticky), .prod_exp(prod_exp));

    always #10 clk = ~clk;

    typedef struct {
        logic [52:0]        sig;
        logic               g;
        logic               s;
        logic signed [12:0] e;
        string              tag;
    } item_t;

    item_t sb[$];
    item_t last;
    int checks = 0, failures = 0, dones = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    function automatic item_t model(input logic [10:0] ea, input logic [51:0] fa,
                                    input logic [10:0] eb, input logic [51:0] fb,
                                    input string tag);
        item_t r;
        logic [52:0]  sa, sbv;
        int           xa, xb, e;
        logic [105:0] p;
        r.tag = tag;
        if ((ea == 0 && fa == 0) || (eb == 0 && fb == 0)) begin
            r.sig = '0; r.g = 0; r.s = 0; r.e = '0;
            return r;
        end
        sa  = {(ea != 0), fa};  xa = (ea != 0) ? int'(ea) : 1;
        sbv = {(eb != 0), fb};  xb = (eb != 0) ? int'(eb) : 1;
        while (!sa[52])  begin sa  = sa  << 1; xa--; end
        while (!sbv[52]) begin sbv = sbv << 1; xb--; end
        p = {53'd0, sa} * {53'd0, sbv};
        e = xa + xb - 1023;
        if (p[105]) begin
            r.sig = p[105:53]; r.g = p[52]; r.s = |p[51:0]; e++;
        end else begin
            r.sig = p[104:52]; r.g = p[51]; r.s = |p[50:0];
        end
        r.e = 13'(e);
        return r;
    endfunction

    // Monitor: compares every done against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (sb.size() == 0) begin
                chk(1'b0, "R7", $sformatf("unexpected done act=1 exp=0"));
            end else begin
                item_t it;
                it = sb.pop_front();
                last = it;
                chk(prod_sig == it.sig, it.tag,
                    $sformatf("sig act=%h exp=%h", prod_sig, it.sig));
                chk(prod_exp == it.e, it.tag,
                    $sformatf("exp act=%0d exp=%0d", prod_exp, it.e));
                chk(prod_guard == it.g && prod_sticky == it.s, it.tag,
                    $sformatf("guard/sticky act=%b%b exp=%b%b",
                              prod_guard, prod_sticky, it.g, it.s));
            end
        end
    end

    // Driver: pushes expectation, launches, returns latency in cycles
    task automatic run_op(input logic [10:0] ea, input logic [51:0] fa,
                          input logic [10:0] eb, input logic [51:0] fb,
                          input string tag, output int lat);
        sb.push_back(model(ea, fa, eb, fb, tag));
        @(negedge clk);
        a_exp = ea; a_frac = fa; b_exp = eb; b_frac = fb; start = 1'b1;
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R6", $sformatf("busy after start act=%b exp=1", busy));
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk(!done && !busy, "R6",
            $sformatf("after pulse done/busy act=%b%b exp=00", done, busy));
    endtask

    initial begin
        int lat;
        int d0;
        logic [52:0] hs;
        logic [12:0] he;
        repeat (3) @(negedge clk);
        chk(!busy && !done && prod_sig == 0 && prod_exp == 0 && !prod_guard && !prod_sticky,
            "R1", $sformatf("reset state act=%b%b %h %0d exp=00 0 0", busy, done, prod_sig, prod_exp));
        rst_n = 1'b1;

        run_op(11'd1023, 52'd0, 11'd1023, 52'd0, "R2", lat);
        chk(lat == 16, "R8", $sformatf("latency act=%0d exp=16", lat));
        run_op(11'd1023, 52'h8_0000_0000_0000, 11'd1023, 52'h8_0000_0000_0000, "R2", lat);
        run_op(11'd1500, {52{1'b1}}, 11'd700, {52{1'b1}}, "R3", lat);
        run_op(11'd1023, 52'd1, 11'd1023, 52'd1, "R3", lat);
        run_op(11'd1100, 52'd3, 11'd900, 52'h4_0000_0000_0000, "R3", lat);
        run_op(11'd0, 52'd1, 11'd1023, 52'h1_2345_6789_abcd, "R4", lat);
        run_op(11'd0, 52'h0_0000_0100_0003, 11'd0, 52'h8_0000_0000_0001, "R9", lat);
        run_op(11'd0, 52'd1, 11'd0, 52'd1, "R9", lat);
        run_op(11'd2046, {52{1'b1}}, 11'd2046, {52{1'b1}}, "R9", lat);
        run_op(11'd0, 52'd0, 11'd1500, 52'h5, "R5", lat);
        chk(lat == 1, "R5", $sformatf("zero latency act=%0d exp=1", lat));
        run_op(11'd0, 52'd7, 11'd0, 52'd0, "R5", lat);

        for (int k = 0; k < 24; k++) begin
            logic [10:0] ea, eb;
            logic [51:0] fa, fb;
            ea = (k % 5 == 0) ? 11'd0 : 11'(1 + ($urandom % 2046));
            eb = (k % 7 == 3) ? 11'd0 : 11'(1 + ($urandom % 2046));
            fa = {$urandom, $urandom} >> (k % 3 == 0 ? 20 : 0);
            fb = {$urandom, $urandom};
            if (ea == 0 && fa == 0) fa = 52'd9;
            run_op(ea, fa, eb, fb, ea == 0 || eb == 0 ? "R4" : "R2", lat);
        end

        // R7: second start while busy must be ignored
        d0 = dones;
        sb.push_back(model(11'd1030, 52'h3_0f0f_0f0f_0f0f, 11'd1010, 52'h7_ffff_0000_1234, "R7"));
        @(negedge clk);
        a_exp = 11'd1030; a_frac = 52'h3_0f0f_0f0f_0f0f;
        b_exp = 11'd1010; b_frac = 52'h7_ffff_0000_1234; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        a_exp = 11'd0; a_frac = 52'd0; b_exp = 11'd5; b_frac = 52'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        a_exp = 11'd1; b_exp = 11'd1;
        repeat (40) @(negedge clk);
        chk(dones == d0 + 1, "R7", $sformatf("done count act=%0d exp=%0d", dones - d0, 1));

        // R10: outputs hold while idle
        hs = prod_sig; he = prod_exp;
        a_frac = 52'hf_ffff; b_frac = 52'h1;
        repeat (10) @(negedge clk);
        chk(prod_sig == hs && prod_exp == he && prod_sig == last.sig, "R10",
            $sformatf("hold act=%h exp=%h", prod_sig, last.sig));
        chk(sb.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", sb.size()));

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule